// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator with Bypass

This block is a second-level interrupt controller. It takes a 32-bit vector of level-sensitive source lines and folds it into a small number of group outputs for a parent controller. A per-output group mask, fixed at build time, assigns sources to that output. The group output is high when any source in its group is both pending and enabled. Sources outside every group and outside the muxable set are unwired: they are dropped everywhere.

A few sources, typically serial-port lines, have a mux gate. When the forward bit for such a source is set, the raw line drives its own direct output with no registers and no enable in the path. The source then no longer counts toward any group output. When the forward bit is clear, the direct output stays low and the source takes the normal aggregated path. An 8-byte register window holds an enable word at offset 0x0 and a read-only raw status word at offset 0x4. A wake output lets the controller pull the system out of suspend. While `sleep_i` is high it is driven combinationally, so it works with the register clock stopped.

Top module: `irq_cascade`

## Requirements
- R1: After reset every enable bit reads 0, all group outputs are low and the wake output is low with sources idle.
- R2: A write with `addr_i[2]`=0 loads the enable word. A read there returns it. Enable bits at unwired positions always read 0.
- R3: A read with `addr_i[2]`=1 returns the raw level of each wired source, including forwarded ones, and 0 at unwired positions. Writes there leave the enable word unchanged.
- R4: Group output g is the OR of source AND enable AND group mask g over non-forwarded sources. It is registered once, so it changes at the first rising edge after its inputs change.
- R5: Unwired sources (default: bits 12 to 31) never raise a group, direct or wake output.
- R6: With `fwd_mask_i` set at a muxable position (default: bits 0 to 2), `direct_o` at that bit follows the raw source with no clock delay and regardless of enable, and the source is excluded from every group output.
- R7: With the forward bit clear, `direct_o` at that position is low and the source drives its group output like any other.
- R8: `fwd_mask_i` bits at non-muxable positions have no effect on any output.
- R9: With `sleep_i` low, `wake_o` equals the OR of the group outputs. With `sleep_i` high, `wake_o` is the unregistered OR of all enabled, pending, non-forwarded grouped sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt sources |
| fwd_mask_i | input | 32 | Per-source bypass select |
| sleep_i | input | 1 | Suspend indication, selects the unclocked wake path |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 3 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 2 | Registered group outputs to the parent |
| direct_o | output | 32 | Bypass outputs, active only at muxable positions |
| wake_o | output | 1 | Wakeup request |

## Verification
The assertions assume that `src_i` and `fwd_mask_i` are synchronous to `clk_i` and settle between edges. They also assume register accesses use word-aligned addresses 0x0 and 0x4. The bench keeps to this: it changes every input only on the falling edge, issues single-cycle strobes and uses only those two offsets. The wake check for the awake case relies on `sleep_i` being held steady around each edge, which the bench also keeps.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned REG_AW     = 3;
  localparam int unsigned SEL_BIT    = 2;
  localparam logic        SEL_ENABLE = 1'b0;
  localparam logic        SEL_STATUS = 1'b1;

  typedef struct packed {
    logic                  req;
    logic                  we;
    logic [REG_AW-1:0]     addr;
  } reg_cmd_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_cascade_pkg::*;
#(
  parameter int unsigned       N_SRC = 32,
  parameter logic [N_SRC-1:0]  WIRED = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_cmd_t         cmd_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] rdata_o
);
  logic [N_SRC-1:0] en_q;
  logic             sel;

  assign sel = cmd_i.addr[SEL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      en_q <= '0;
    else if (cmd_i.req && cmd_i.we && sel == SEL_ENABLE)
      en_q <= wdata_i & WIRED;
  end

  always_comb begin
    rdata_o = '0;
    if (cmd_i.req && !cmd_i.we)
      rdata_o = (sel == SEL_STATUS) ? (src_i & WIRED) : en_q;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_bypass.sv
module irq_bypass #(
  parameter int unsigned      N_SRC    = 32,
  parameter logic [N_SRC-1:0] MUX_MASK = '0
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] fwd_mask_i,
  output logic [N_SRC-1:0] fwd_eff_o,
  output logic [N_SRC-1:0] direct_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (MUX_MASK[i]) begin : g_mux
      assign fwd_eff_o[i] = fwd_mask_i[i];
      assign direct_o[i]  = fwd_mask_i[i] & src_i[i];
    end else begin : g_nomux
      assign fwd_eff_o[i] = 1'b0;
      assign direct_o[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned      N_SRC = 32,
  parameter logic [N_SRC-1:0] MAP   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] fwd_eff_i,
  output logic             pend_o,
  output logic             irq_o
);
  logic irq_q;

  assign pend_o = |(src_i & en_i & MAP & ~fwd_eff_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pend_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
  import irq_cascade_pkg::*;
#(
  parameter int unsigned                   N_SRC    = 32,
  parameter int unsigned                   N_GRP    = 2,
  parameter logic [N_GRP-1:0][N_SRC-1:0]   MAP_MASK = {32'h0000_0140, 32'h0000_0EBF},
  parameter logic [N_SRC-1:0]              MUX_MASK = 32'h0000_0007,
  parameter bit                            WAKE_EN  = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_SRC-1:0]     src_i,
  input  logic [N_SRC-1:0]     fwd_mask_i,
  input  logic                 sleep_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  logic [N_SRC-1:0]     wdata_i,
  output logic [N_SRC-1:0]     rdata_o,
  output logic [N_GRP-1:0]     irq_o,
  output logic [N_SRC-1:0]     direct_o,
  output logic                 wake_o
);
  function automatic logic [N_SRC-1:0] wired_set();
    logic [N_SRC-1:0] acc = MUX_MASK;
    for (int g = 0; g < N_GRP; g++) acc |= MAP_MASK[g];
    return acc;
  endfunction

  localparam logic [N_SRC-1:0] WIRED = wired_set();

  reg_cmd_t         cmd;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] fwd_eff;
  logic [N_GRP-1:0] pend;

  assign cmd = '{req: req_i, we: we_i, addr: addr_i};

  irq_regs #(.N_SRC(N_SRC), .WIRED(WIRED)) u_regs (
    .clk_i, .rst_ni, .cmd_i(cmd), .wdata_i, .src_i, .en_o(en_q), .rdata_o
  );

  irq_bypass #(.N_SRC(N_SRC), .MUX_MASK(MUX_MASK)) u_bypass (
    .src_i, .fwd_mask_i, .fwd_eff_o(fwd_eff), .direct_o
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    irq_group #(.N_SRC(N_SRC), .MAP(MAP_MASK[g])) u_grp (
      .clk_i, .rst_ni, .src_i, .en_i(en_q), .fwd_eff_i(fwd_eff),
      .pend_o(pend[g]), .irq_o(irq_o[g])
    );
  end

  if (WAKE_EN) begin : g_wake
    // unclocked path while the register clock may be stopped
    assign wake_o = sleep_i ? |pend : |irq_o;
  end else begin : g_nowake
    assign wake_o = 1'b0;
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
  parameter int unsigned      N_SRC    = 32,
  parameter int unsigned      N_GRP    = 2,
  parameter logic [N_SRC-1:0] MUX_MASK = '0,
  parameter bit               WAKE_EN  = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_i,
  input logic [N_SRC-1:0] fwd_mask_i,
  input logic             sleep_i,
  input logic             req_i,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic [N_GRP-1:0] irq_o,
  input logic [N_SRC-1:0] direct_o,
  input logic             wake_o,
  input logic [N_SRC-1:0] en_q
);
  AST_DIRECT_NEEDS_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct_o & ~(fwd_mask_i & MUX_MASK)) == '0); // R7
  AST_DIRECT_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct_o & ~src_i) == '0); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(|(src_i & en_q))); // R4
  AST_STATUS_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[2]) |=> $stable(en_q)); // R3
  AST_WAKE_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && WAKE_EN) |-> (wake_o == |irq_o)); // R9
endmodule

bind irq_cascade irq_cascade_chk #(
  .N_SRC(N_SRC), .N_GRP(N_GRP), .MUX_MASK(MUX_MASK), .WAKE_EN(WAKE_EN)
) u_chk (
  .clk_i, .rst_ni, .src_i, .fwd_mask_i, .sleep_i, .req_i, .we_i, .addr_i,
  .irq_o, .direct_o, .wake_o, .en_q
);

// File: tb/sim_irq_cascade.sv
`timescale 1ns/1ps
module sim_irq_cascade;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic [31:0] fwd_mask_i = '0;
  logic        sleep_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o;
  logic [31:0] direct_o;
  logic        wake_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  irq_cascade u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  // set sources at a falling edge, then sample one rising edge later
  task automatic drive(logic [31:0] s, logic [31:0] f);
    @(negedge clk_i);
    src_i = s; fwd_mask_i = f;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'h0, d);
    chk("R1 enable", d, 32'h0);
    chk("R1 irq", {30'h0, irq_o}, 32'h0);
    chk("R1 wake", {31'h0, wake_o}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3'h0, 32'hFFFF_FFFF);
    rd(3'h0, d);
    chk("R2 wired enables", d, 32'h0000_0FFF);
    wr(3'h4, 32'h0);
    rd(3'h0, d);
    chk("R3 status write ignored", d, 32'h0000_0FFF);
    wr(3'h0, 32'h0000_0A5A);
    rd(3'h0, d);
    chk("R2 readback", d, 32'h0000_0A5A);
  endtask

  task automatic t_status();
    logic [31:0] d;
    drive(32'hFFFF_F5A5, 32'h7);
    rd(3'h4, d);
    chk("R3 raw status", d, 32'h0000_05A5);
    drive(32'h0, 32'h0);
  endtask

  task automatic t_group();
    wr(3'h0, 32'hFFF);
    @(negedge clk_i);
    src_i = 32'h8;
    #1 chk("R4 not before edge", {30'h0, irq_o}, 32'h0);
    @(negedge clk_i);
    chk("R4 group0", {30'h0, irq_o}, 32'h1);
    drive(32'h40, 32'h0);
    chk("R4 group1", {30'h0, irq_o}, 32'h2);
    drive(32'h110, 32'h0);
    chk("R4 both", {30'h0, irq_o}, 32'h3);
    wr(3'h0, 32'h0);
    @(negedge clk_i);
    chk("R4 disabled", {30'h0, irq_o}, 32'h0);
    drive(32'h0, 32'h0);
  endtask

  task automatic t_unwired();
    wr(3'h0, 32'hFFFF_FFFF);
    drive(32'hFFFF_F000, 32'hFFFF_FFFF);
    chk("R5 irq", {30'h0, irq_o}, 32'h0);
    chk("R5 direct", direct_o, 32'h0);
    chk("R5 wake", {31'h0, wake_o}, 32'h0);
    drive(32'h0, 32'h0);
  endtask

  task automatic t_fwd();
    wr(3'h0, 32'hFFF);
    drive(32'h2, 32'h7);
    chk("R6 direct", direct_o, 32'h2);
    chk("R6 excluded", {30'h0, irq_o}, 32'h0);
    drive(32'h2, 32'h0);
    chk("R7 direct low", direct_o, 32'h0);
    chk("R7 aggregated", {30'h0, irq_o}, 32'h1);
    wr(3'h0, 32'h0);
    @(negedge clk_i);
    fwd_mask_i = 32'h7; src_i = 32'h5;
    #1 chk("R6 unclocked no enable", direct_o, 32'h5);
    drive(32'h0, 32'h0);
  endtask

  task automatic t_fwd_nonmux();
    wr(3'h0, 32'hFFF);
    drive(32'h8, 32'hFFFF_FFF8);
    chk("R8 irq", {30'h0, irq_o}, 32'h1);
    chk("R8 direct", direct_o, 32'h0);
    drive(32'h0, 32'h0);
  endtask

  task automatic t_wake();
    wr(3'h0, 32'hFFF);
    @(negedge clk_i);
    sleep_i = 1'b1; src_i = 32'h40;
    #1 chk("R9 sleep unclocked", {31'h0, wake_o}, 32'h1);
    @(negedge clk_i);
    fwd_mask_i = 32'h1; src_i = 32'h1;
    #1 chk("R9 sleep forwarded", {31'h0, wake_o}, 32'h0);
    @(negedge clk_i);
    sleep_i = 1'b0; fwd_mask_i = 32'h0; src_i = 32'h40;
    #1 chk("R9 awake follows irq", {31'h0, wake_o}, {31'h0, |irq_o});
    @(negedge clk_i);
    chk("R9 awake high", {31'h0, wake_o}, 32'h1);
    drive(32'h0, 32'h0);
    chk("R9 awake low", {31'h0, wake_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_status();
    t_group();
    t_unwired();
    t_fwd();
    t_fwd_nonmux();
    t_wake();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule